// File: doc/BRIEF.md
# Miss-Stride Prefetch Address Generator

This block watches the demand misses of a cache. Each miss carries an address and a requester ID. The block reduces every miss address to its cache-block address and keeps, for each requester, the two block addresses that missed before it. When the distance from the previous miss to the newest one equals the distance between the two misses before that, the requester is walking memory with a constant stride. The block then produces prefetch candidates further along that stride, one per cycle.

Each candidate is presented on a lookup address output. Two presence inputs answer in the same cycle: one says whether the block is already in the cache, the other whether it is already waiting in the miss queue. A candidate that hits either one is dropped and counted. A candidate that would leave the virtual page of the triggering miss ends the burst when page-stop is selected, and the unused slots are counted. Surviving candidates go out through a registered valid/ready port together with a fixed issue-latency tag. While a burst is being worked through, the miss input is held off.

Top module: `stride_pf_gen`

## Requirements
- R1: A miss address is aligned to its block by clearing its low log2(BLOCK_BYTES) bits. Every issued prefetch address is block aligned.
- R2: With `cfg_per_req`=1 each requester ID has its own history pair, holding the last and the second-last block addresses. Misses of one ID never change another ID's trigger decision.
- R3: With `cfg_per_req`=0 every miss reads and updates history slot 0, whatever its ID.
- R4: On every accepted miss the history shifts: second-last takes the old last value and last takes the new block address, whether or not a burst starts. A burst starts only when (block − last) equals (last − second-last) as signed values. History is all zero after reset, so a first miss to block 0 triggers with stride 0.
- R5: A burst produces candidate d = block + d·stride for d = 1 to DEGREE, in increasing d order. Negative and zero strides are included.
- R6: With `cfg_page_stop`=1, the first candidate d whose page (address / PAGE_BYTES) differs from the page of the triggering block ends the burst unissued, and `cnt_span` increases by DEGREE − d + 1. With `cfg_page_stop`=0, candidates cross pages freely.
- R7: A candidate for which `lk_in_cache`=1 is not issued and `cnt_cache_hit` increases by 1. This check wins when both presence inputs are high.
- R8: A candidate with `lk_in_cache`=0 and `lk_in_queue`=1 is not issued and `cnt_queue_hit` increases by 1.
- R9: Every issued prefetch carries `pf_lat` = ISSUE_LAT.
- R10: While `pf_valid`=1 and `pf_ready`=0, `pf_valid` stays high and `pf_addr` stays stable. `miss_ready` stays low from the acceptance of a triggering miss until the burst has been fully worked through.
- R11: After reset, `pf_valid`=0, `miss_ready`=1 and all three counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_per_req | input | 1 | 1: history per requester ID; 0: all misses share slot 0 |
| cfg_page_stop | input | 1 | 1: end a burst at the first page crossing |
| miss_valid | input | 1 | Miss offered |
| miss_ready | output | 1 | Miss accepted when high together with miss_valid |
| miss_addr | input | ADDR_W | Miss byte address |
| miss_id | input | log2(NUM_REQ) | Requester ID of the miss |
| lk_addr | output | ADDR_W | Candidate address being looked up |
| lk_in_cache | input | 1 | Candidate is already in the cache |
| lk_in_queue | input | 1 | Candidate is already pending in the miss queue |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Consumer takes the prefetch |
| pf_addr | output | ADDR_W | Prefetch block address |
| pf_lat | output | LAT_W | Issue latency tag |
| cnt_span | output | CNT_W | Slots lost to page crossings |
| cnt_cache_hit | output | CNT_W | Candidates dropped as cache hits |
| cnt_queue_hit | output | CNT_W | Candidates dropped as miss-queue hits |

## Verification
The hardest state to reach is a burst that stops partway through. That happens only when a stride has been confirmed on a block that sits just below a page boundary, and it takes three misses from one requester that land in exactly the right place. The bench reaches it with a dedicated ID that walks toward a page end. It repeats the same walk with page-stop off, to show that the candidates then cross the page. Drops caused by the presence inputs need the bench to answer the lookup for one chosen candidate address in the middle of a burst, including a case where both inputs answer for the same candidate. Shared-slot history is shown by three IDs that together form a stride that no single ID could form alone.

// File: rtl/pf_pkg.sv
package pf_pkg;
   // outcome of one candidate in the cycle it is resolved
   typedef enum logic [1:0] {
      CAND_ISSUE = 2'd0,
      CAND_CACHE = 2'd1,
      CAND_QUEUE = 2'd2,
      CAND_SPAN  = 2'd3
   } cand_kind_e;
endpackage

// File: rtl/pf_hist.sv
module pf_hist #(
   parameter int ADDR_W  = 32,
   parameter int NUM_REQ = 64,
   localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ID_W-1:0]   slot,
   input  logic [ADDR_W-1:0] new_blk,
   output logic [ADDR_W-1:0] last_blk,
   output logic [ADDR_W-1:0] prev_blk
);
   logic [ADDR_W-1:0] last_q [NUM_REQ];
   logic [ADDR_W-1:0] prev_q [NUM_REQ];

   assign last_blk = last_q[slot];
   assign prev_blk = prev_q[slot];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REQ; i++) begin
            last_q[i] <= '0;
            prev_q[i] <= '0;
         end
      end else if (wr_en) begin
         prev_q[slot] <= last_q[slot];
         last_q[slot] <= new_blk;
      end
   end
endmodule

// File: rtl/pf_step.sv
module pf_step
   import pf_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DEGREE     = 4,
   parameter int PAGE_BYTES = 4096,
   parameter int CNT_W      = 16,
   localparam int PG_SH     = $clog2(PAGE_BYTES),
   localparam int DW        = $clog2(DEGREE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   input  logic              adv,
   input  logic              page_stop,
   input  logic              in_cache,
   input  logic              in_queue,
   output logic              busy,
   output logic [ADDR_W-1:0] cand_addr,
   output cand_kind_e        kind,
   output logic [CNT_W-1:0]  span_add
);
   logic [ADDR_W-1:0] base_q, stride_q, cand_q;
   logic [DW-1:0]     d_q;
   logic              busy_q;
   logic              crosses;

   assign busy      = busy_q;
   assign cand_addr = cand_q;
   assign crosses   = cand_q[ADDR_W-1:PG_SH] != base_q[ADDR_W-1:PG_SH];
   assign span_add  = CNT_W'(DEGREE) - CNT_W'(d_q) + CNT_W'(1);

   always_comb begin
      if (page_stop && crosses) kind = CAND_SPAN;
      else if (in_cache)        kind = CAND_CACHE;
      else if (in_queue)        kind = CAND_QUEUE;
      else                      kind = CAND_ISSUE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         base_q   <= '0;
         stride_q <= '0;
         cand_q   <= '0;
         d_q      <= '0;
      end else if (start) begin
         busy_q   <= 1'b1;
         base_q   <= base;
         stride_q <= stride;
         cand_q   <= base + stride;
         d_q      <= DW'(1);
      end else if (busy_q && adv) begin
         if (kind == CAND_SPAN || d_q == DW'(DEGREE)) begin
            busy_q <= 1'b0;
         end else begin
            d_q    <= d_q + DW'(1);
            cand_q <= cand_q + stride_q;
         end
      end
   end
endmodule

// File: rtl/pf_outreg.sv
module pf_outreg #(
   parameter int ADDR_W    = 32,
   parameter int LAT_W     = 8,
   parameter int ISSUE_LAT = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              free,
   output logic              valid,
   input  logic              ready,
   output logic [ADDR_W-1:0] addr,
   output logic [LAT_W-1:0]  lat
);
   assign free = !valid || ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         addr  <= '0;
         lat   <= '0;
      end else if (load) begin
         valid <= 1'b1;
         addr  <= addr_in;
         lat   <= LAT_W'(ISSUE_LAT);
      end else if (ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/pf_ctr.sv
module pf_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic [CNT_W-1:0] amt,
   output logic [CNT_W-1:0] val
);
   always_ff @(posedge clk) begin
      if (!rst_n)   val <= '0;
      else if (inc) val <= val + amt;
   end
endmodule

// File: rtl/stride_pf_gen.sv
module stride_pf_gen
   import pf_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_BYTES = 64,
   parameter int PAGE_BYTES  = 4096,
   parameter int NUM_REQ     = 64,
   parameter int DEGREE      = 4,
   parameter int LAT_W       = 8,
   parameter int ISSUE_LAT   = 20,
   parameter int CNT_W       = 16,
   localparam int ID_W       = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
   localparam int BLK_SH     = $clog2(BLOCK_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_per_req,
   input  logic              cfg_page_stop,
   input  logic              miss_valid,
   output logic              miss_ready,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic [ID_W-1:0]   miss_id,
   output logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_in_cache,
   input  logic              lk_in_queue,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [ADDR_W-1:0] pf_addr,
   output logic [LAT_W-1:0]  pf_lat,
   output logic [CNT_W-1:0]  cnt_span,
   output logic [CNT_W-1:0]  cnt_cache_hit,
   output logic [CNT_W-1:0]  cnt_queue_hit
);
   localparam int NCTR = 3;

   if (BLOCK_BYTES < 2 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("BLOCK_BYTES must be a power of two of at least 2");
   end
   if (PAGE_BYTES < BLOCK_BYTES || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two not below BLOCK_BYTES");
   end
   if (DEGREE < 1 || NUM_REQ < 1 || NUM_REQ > 64) begin : g_bad_count
      $error("DEGREE must be at least 1 and NUM_REQ between 1 and 64");
   end
   if ((1 << BLK_SH) >= (1 << ($clog2(PAGE_BYTES) + 1)) || ADDR_W <= $clog2(PAGE_BYTES)) begin : g_bad_width
      $error("ADDR_W too narrow for the page size");
   end

   logic              accept, start, gen_busy, out_free, fire;
   logic [ADDR_W-1:0] blk, h_last, h_prev, stride_new, stride_old;
   logic [ID_W-1:0]   slot;
   cand_kind_e        kind;
   logic [CNT_W-1:0]  span_add;

   assign miss_ready = !gen_busy;
   assign accept     = miss_valid && miss_ready;
   assign blk        = {miss_addr[ADDR_W-1:BLK_SH], BLK_SH'(0)};
   assign slot       = cfg_per_req ? miss_id : '0;
   assign stride_new = blk - h_last;
   assign stride_old = h_last - h_prev;
   assign start      = accept && (stride_new == stride_old);
   assign fire       = gen_busy && out_free;

   pf_hist #(.ADDR_W(ADDR_W), .NUM_REQ(NUM_REQ)) u_hist (
      .clk(clk), .rst_n(rst_n), .wr_en(accept), .slot(slot),
      .new_blk(blk), .last_blk(h_last), .prev_blk(h_prev)
   );

   pf_step #(.ADDR_W(ADDR_W), .DEGREE(DEGREE), .PAGE_BYTES(PAGE_BYTES),
             .CNT_W(CNT_W)) u_step (
      .clk(clk), .rst_n(rst_n), .start(start), .base(blk),
      .stride(stride_new), .adv(out_free), .page_stop(cfg_page_stop),
      .in_cache(lk_in_cache), .in_queue(lk_in_queue), .busy(gen_busy),
      .cand_addr(lk_addr), .kind(kind), .span_add(span_add)
   );

   pf_outreg #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .ISSUE_LAT(ISSUE_LAT)) u_out (
      .clk(clk), .rst_n(rst_n), .load(fire && kind == CAND_ISSUE),
      .addr_in(lk_addr), .free(out_free), .valid(pf_valid),
      .ready(pf_ready), .addr(pf_addr), .lat(pf_lat)
   );

   logic [NCTR-1:0]  c_inc;
   logic [CNT_W-1:0] c_amt [NCTR];
   logic [CNT_W-1:0] c_val [NCTR];

   assign c_inc[0] = fire && kind == CAND_SPAN;
   assign c_inc[1] = fire && kind == CAND_CACHE;
   assign c_inc[2] = fire && kind == CAND_QUEUE;
   assign c_amt[0] = span_add;
   assign c_amt[1] = CNT_W'(1);
   assign c_amt[2] = CNT_W'(1);

   for (genvar g = 0; g < NCTR; g++) begin : g_ctr
      pf_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk(clk), .rst_n(rst_n), .inc(c_inc[g]), .amt(c_amt[g]), .val(c_val[g])
      );
   end

   assign cnt_span      = c_val[0];
   assign cnt_cache_hit = c_val[1];
   assign cnt_queue_hit = c_val[2];
endmodule

// File: rtl/pf_gen_chk.sv
module pf_gen_chk #(
   parameter int ADDR_W    = 32,
   parameter int BLK_SH    = 6,
   parameter int LAT_W     = 8,
   parameter int ISSUE_LAT = 20,
   parameter int CNT_W     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pf_valid,
   input logic              pf_ready,
   input logic [ADDR_W-1:0] pf_addr,
   input logic [LAT_W-1:0]  pf_lat,
   input logic [CNT_W-1:0]  cnt_cache_hit,
   input logic [CNT_W-1:0]  cnt_queue_hit,
   input logic              gen_busy
);
   a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> pf_addr[BLK_SH-1:0] == '0);

   a_r9_latency_tag: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> pf_lat == LAT_W'(ISSUE_LAT));

   a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

   a_r10_issue_from_burst: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pf_valid) |-> $past(gen_busy));

   a_r7_cache_step: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_cache_hit == $past(cnt_cache_hit) ||
      cnt_cache_hit == $past(cnt_cache_hit) + CNT_W'(1));

   a_r8_queue_step: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_queue_hit == $past(cnt_queue_hit) ||
      cnt_queue_hit == $past(cnt_queue_hit) + CNT_W'(1));
endmodule

bind stride_pf_gen pf_gen_chk #(
   .ADDR_W(ADDR_W), .BLK_SH(BLK_SH), .LAT_W(LAT_W),
   .ISSUE_LAT(ISSUE_LAT), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_ready(pf_ready),
   .pf_addr(pf_addr), .pf_lat(pf_lat), .cnt_cache_hit(cnt_cache_hit),
   .cnt_queue_hit(cnt_queue_hit), .gen_busy(gen_busy)
);

// File: tb/test_stride_pf_gen.sv
`timescale 1ns/1ps
module test_stride_pf_gen;
   localparam int LAT = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_per_req = 1'b1, cfg_page_stop = 1'b1;
   logic        miss_valid = 1'b0, miss_ready;
   logic [31:0] miss_addr = '0;
   logic [5:0]  miss_id = '0;
   logic [31:0] lk_addr;
   logic        lk_in_cache, lk_in_queue;
   logic        pf_valid, pf_ready = 1'b1;
   logic [31:0] pf_addr;
   logic [7:0]  pf_lat;
   logic [15:0] cnt_span, cnt_cache_hit, cnt_queue_hit;

   logic        cache_on = 1'b0, queue_on = 1'b0;
   logic [31:0] cache_tgt = '0, queue_tgt = '0;

   assign lk_in_cache = cache_on && (lk_addr == cache_tgt);
   assign lk_in_queue = queue_on && (lk_addr == queue_tgt);

   always #4 clk = ~clk;

   stride_pf_gen i_stride_pf_gen (
      .clk(clk), .rst_n(rst_n), .cfg_per_req(cfg_per_req),
      .cfg_page_stop(cfg_page_stop), .miss_valid(miss_valid),
      .miss_ready(miss_ready), .miss_addr(miss_addr), .miss_id(miss_id),
      .lk_addr(lk_addr), .lk_in_cache(lk_in_cache), .lk_in_queue(lk_in_queue),
      .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
      .pf_lat(pf_lat), .cnt_span(cnt_span), .cnt_cache_hit(cnt_cache_hit),
      .cnt_queue_hit(cnt_queue_hit)
   );

   int checks = 0, failures = 0;
   bit done = 0;
   logic [31:0] rec [16];
   int rec_n = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // transfer happens at the following posedge; inputs only move after posedges
   always @(negedge clk) begin
      if (rst_n && pf_valid && pf_ready) begin
         if (rec_n < 16) rec[rec_n] = pf_addr;
         rec_n++;
         chk(pf_lat == 8'(LAT), "R9 latency tag", 32'(pf_lat), 32'(LAT));
      end
   end

   task automatic do_miss(input logic [31:0] a, input logic [5:0] id);
      @(posedge clk); #1;
      miss_valid = 1'b1; miss_addr = a; miss_id = id;
      forever begin
         @(negedge clk);
         if (miss_ready) break;
      end
      @(posedge clk); #1;
      miss_valid = 1'b0;
      forever begin
         @(negedge clk);
         if (miss_ready && !pf_valid) break;
      end
   endtask

   task automatic check_burst(input int n, input logic [31:0] first,
                              input logic [31:0] step, input string req);
      chk(rec_n == n, req, 32'(rec_n), 32'(n));
      for (int k = 0; k < n && k < rec_n && k < 16; k++) begin
         chk(rec[k] == first + 32'(k) * step, req, rec[k], first + 32'(k) * step);
      end
   endtask

   typedef struct packed {
      logic [31:0] addr;
      logic [5:0]  id;
      logic [3:0]  n;
      logic [31:0] first;
      logic [31:0] step;
   } vec_t;

   // per-requester history, page-stop on, no presence hits
   localparam vec_t VECS [11] = '{
      '{32'h1000_0000, 6'd1, 4'd0, 32'h0,          32'h0},
      '{32'h1000_0040, 6'd1, 4'd0, 32'h0,          32'h0},
      '{32'h1000_0085, 6'd1, 4'd4, 32'h1000_00C0,  32'h40},
      '{32'h2000_0000, 6'd2, 4'd0, 32'h0,          32'h0},
      '{32'h1000_00C0, 6'd1, 4'd4, 32'h1000_0100,  32'h40},
      '{32'h2000_0100, 6'd2, 4'd0, 32'h0,          32'h0},
      '{32'h2000_0200, 6'd2, 4'd4, 32'h2000_0300,  32'h100},
      '{32'h1000_0040, 6'd1, 4'd0, 32'h0,          32'h0},
      '{32'h1000_0000, 6'd1, 4'd0, 32'h0,          32'h0},
      '{32'h0FFF_FFC0, 6'd1, 4'd4, 32'h0FFF_FF80,  32'hFFFF_FFC0},
      '{32'h0000_0010, 6'd3, 4'd4, 32'h0,          32'h0}
   };

   initial begin
      #(8 * 200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(pf_valid == 1'b0, "R11 pf_valid", 32'(pf_valid), 0);
      chk(miss_ready == 1'b1, "R11 miss_ready", 32'(miss_ready), 1);
      chk(cnt_span == 0 && cnt_cache_hit == 0 && cnt_queue_hit == 0,
          "R11 counters", 32'(cnt_span) | 32'(cnt_cache_hit) | 32'(cnt_queue_hit), 0);

      // R1 R2 R4 R5: table walk (alignment, isolation, trigger, neg/zero stride)
      foreach (VECS[i]) begin
         rec_n = 0;
         do_miss(VECS[i].addr, VECS[i].id);
         check_burst(int'(VECS[i].n), VECS[i].first, VECS[i].step, "R2 R4 R5 table");
      end

      // R6: page-stop truncates after one candidate, span += DEGREE-2+1
      rec_n = 0; do_miss(32'h3000_0F00, 6'd4);
      rec_n = 0; do_miss(32'h3000_0F40, 6'd4);
      rec_n = 0; do_miss(32'h3000_0F80, 6'd4);
      check_burst(1, 32'h3000_0FC0, 32'h40, "R6 truncated burst");
      chk(cnt_span == 16'd3, "R6 span count", 32'(cnt_span), 3);

      // R6: page-stop off, the burst crosses the page
      cfg_page_stop = 1'b0;
      rec_n = 0; do_miss(32'h3100_0F00, 6'd5);
      rec_n = 0; do_miss(32'h3100_0F40, 6'd5);
      rec_n = 0; do_miss(32'h3100_0F80, 6'd5);
      check_burst(4, 32'h3100_0FC0, 32'h40, "R6 crossing allowed");
      chk(cnt_span == 16'd3, "R6 span unchanged", 32'(cnt_span), 3);
      cfg_page_stop = 1'b1;

      // R7 R8: one cache hit, one queue hit
      rec_n = 0; do_miss(32'h4000_0000, 6'd6);
      rec_n = 0; do_miss(32'h4000_0040, 6'd6);
      cache_on = 1'b1; cache_tgt = 32'h4000_00C0;
      queue_on = 1'b1; queue_tgt = 32'h4000_0100;
      rec_n = 0; do_miss(32'h4000_0080, 6'd6);
      check_burst(2, 32'h4000_0140, 32'h40, "R7 R8 dropped candidates");
      chk(cnt_cache_hit == 16'd1, "R7 cache count", 32'(cnt_cache_hit), 1);
      chk(cnt_queue_hit == 16'd1, "R8 queue count", 32'(cnt_queue_hit), 1);

      // R7: both inputs hit the same candidate, only the cache counter moves
      cache_on = 1'b0; queue_on = 1'b0;
      rec_n = 0; do_miss(32'h5000_0000, 6'd7);
      rec_n = 0; do_miss(32'h5000_0040, 6'd7);
      cache_on = 1'b1; cache_tgt = 32'h5000_00C0;
      queue_on = 1'b1; queue_tgt = 32'h5000_00C0;
      rec_n = 0; do_miss(32'h5000_0080, 6'd7);
      check_burst(3, 32'h5000_0100, 32'h40, "R7 both hit");
      chk(cnt_cache_hit == 16'd2, "R7 cache precedence", 32'(cnt_cache_hit), 2);
      chk(cnt_queue_hit == 16'd1, "R8 queue unchanged", 32'(cnt_queue_hit), 1);
      cache_on = 1'b0; queue_on = 1'b0;

      // R3: shared slot 0 forms a stride across three IDs
      cfg_per_req = 1'b0;
      rec_n = 0; do_miss(32'h6000_0000, 6'd8);
      rec_n = 0; do_miss(32'h6000_0040, 6'd9);
      rec_n = 0; do_miss(32'h6000_0080, 6'd10);
      check_burst(4, 32'h6000_00C0, 32'h40, "R3 shared history");
      cfg_per_req = 1'b1;

      // R10: back-pressure holds the first prefetch and the miss input
      rec_n = 0; do_miss(32'h7000_0000, 6'd11);
      rec_n = 0; do_miss(32'h7000_0040, 6'd11);
      rec_n = 0;
      @(posedge clk); #1;
      pf_ready = 1'b0;
      miss_valid = 1'b1; miss_addr = 32'h7000_0080; miss_id = 6'd11;
      @(posedge clk); #1;
      miss_valid = 1'b0;
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk(pf_valid == 1'b1, "R10 valid held", 32'(pf_valid), 1);
      chk(pf_addr == 32'h7000_00C0, "R10 addr held", pf_addr, 32'h7000_00C0);
      chk(miss_ready == 1'b0, "R10 miss held off", 32'(miss_ready), 0);
      @(posedge clk); #1;
      pf_ready = 1'b1;
      forever begin
         @(negedge clk);
         if (miss_ready && !pf_valid) break;
      end
      check_burst(4, 32'h7000_00C0, 32'h40, "R10 burst after release");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule